// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block is a small cache that sits between a requesting processor port and a slower backing store. The backing store holds 256 bytes. The cache has eight single-byte lines. Each line keeps a valid flag, a 5-bit tag and one data byte. The three least significant address bits select the line, which is the address modulo eight. The five upper bits are kept as the tag. They identify which of the 32 competing addresses currently occupies the line.

A read that finds a valid line with a matching tag is answered from the cache. A read that does not is sent to the backing store. The returned byte is then placed in the selected line with the new tag, which displaces any earlier occupant. Every store goes to the backing store. The selected line is refreshed with the new byte and tag in the same cycle, so the cache never holds a value that differs from memory.

Both sides use a simple request/ready handshake. Two counters report how many reads were hits and how many were misses.

Top module: `dmc_cache`

## Requirements
- R1: After reset, all lines are invalid and `cpu_ready` is 1. `cpu_done`, `mem_req`, `hit_count` and `miss_count` are all 0. A reset in the middle of operation makes every earlier line content miss again.
- R2: Line index is `addr[2:0]` and tag is `addr[7:3]`. A read miss presents the requested address on `mem_addr` with `mem_we` = 0.
- R3: A line that has not been filled since reset never produces a hit, whatever the address.
- R4: A read of a valid line with a matching tag does not access memory. It asserts `cpu_done` in the cycle after acceptance, with the cached byte on `cpu_rdata`.
- R5: A read miss returns the byte that memory supplied. It fills the line, so the next read of the same address is a hit.
- R6: Every write is forwarded to memory with `mem_we` = 1 and the written address and byte. It also fills the line, so a later read of that address hits and returns the new byte.
- R7: Two addresses with the same low 3 bits cannot both be resident. Accessing one, by a read miss or by a write, evicts the other.
- R8: While a memory access is outstanding, `cpu_ready` stays 0. `cpu_done` rises in the cycle after `mem_ready`. Read-miss and write latency, counted from acceptance, is the memory wait plus 2 cycles.
- R9: A request is accepted only when `cpu_req` and `cpu_ready` are both 1. `cpu_done` is a single-cycle pulse.
- R10: `hit_count` increments by one per read hit and `miss_count` by one per read miss. Writes change neither counter.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are held stable until memory answers with `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Idle; a request is accepted this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_done` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory has accepted the write or supplies read data |
| mem_rdata | input | 8 | Memory read byte |
| hit_count | output | 16 | Read hits since reset |
| miss_count | output | 16 | Read misses since reset |

## Verification
The hardest case to reach from the ports is an eviction followed by a return to the displaced address. A plain read-back cannot tell a stale line from a correct one, because the backing store still holds the same value. The stimulus therefore writes to or reads from a second address with the same index. It then reads the first address again and checks that the read takes the slower memory path and that `miss_count` steps. A long pseudo-random sequence confined to a few tags per index repeats this case many times. Every returned byte is compared against a flat memory model, and hits are predicted by an independent per-line tag model.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_STORE = 2'd2,
        ST_RESP  = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_comb begin
        valid_d = valid_q;
        if (fill_en) valid_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // Tag and data carry no reset; the valid flag guards them.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (fill_en && (fill_idx == IDX_W'(g))) begin
                tag_q[g]  <= fill_tag;
                data_q[g] <= fill_data;
            end
        end
    end

    assign lk_valid = valid_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign lk_data  = data_q[lk_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ready,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [IDX_W-1:0]        lk_idx,
    input  logic                    lk_valid,
    input  logic [ADDR_W-IDX_W-1:0] lk_tag,
    input  logic [DATA_W-1:0]       lk_data,
    output logic                    fill_en,
    output logic [IDX_W-1:0]        fill_idx,
    output logic [ADDR_W-IDX_W-1:0] fill_tag,
    output logic [DATA_W-1:0]       fill_data,
    output logic                    hit_evt,
    output logic                    miss_evt
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        dmc_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  accept;
    logic  tag_eq;

    assign lk_idx = cpu_addr[IDX_W-1:0];
    assign tag_eq = (lk_tag == cpu_addr[ADDR_W-1:IDX_W]);

    always_comb begin
        s_d      = s_q;
        accept   = 1'b0;
        hit_evt  = 1'b0;
        miss_evt = 1'b0;
        fill_en  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    accept    = 1'b1;
                    s_d.addr  = cpu_addr;
                    s_d.wdata = cpu_wdata;
                    if (cpu_we) begin
                        s_d.st = ST_STORE;
                    end else if (lk_valid && tag_eq) begin
                        hit_evt   = 1'b1;
                        s_d.rdata = lk_data;
                        s_d.st    = ST_RESP;
                    end else begin
                        miss_evt = 1'b1;
                        s_d.st   = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ready) begin
                    fill_en   = 1'b1;
                    s_d.rdata = mem_rdata;
                    s_d.st    = ST_RESP;
                end
            end
            ST_STORE: begin
                if (mem_ready) begin
                    fill_en = 1'b1;
                    s_d.st  = ST_RESP;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_ready = (s_q.st == ST_IDLE);
    assign cpu_done  = (s_q.st == ST_RESP);
    assign cpu_rdata = s_q.rdata;
    assign mem_req   = (s_q.st == ST_FILL) || (s_q.st == ST_STORE);
    assign mem_we    = (s_q.st == ST_STORE);
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.wdata;
    assign fill_idx  = s_q.addr[IDX_W-1:0];
    assign fill_tag  = s_q.addr[ADDR_W-1:IDX_W];
    assign fill_data = (s_q.st == ST_FILL) ? mem_rdata : s_q.wdata;

    logic unused_accept;
    assign unused_accept = accept & (TAG_W > 0);
endmodule

// File: rtl/dmc_event_count.sv
module dmc_event_count #(
    parameter int CNT_W = 16,
    parameter int NUM   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM-1:0]       evt,
    output logic [NUM*CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        logic [CNT_W-1:0] c_d, c_q;
        always_comb c_d = evt[g] ? c_q + CNT_W'(1) : c_q;
        always_ff @(posedge clk) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end
        assign cnt[g*CNT_W +: CNT_W] = c_q;
    end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]   lk_idx, fill_idx;
    logic               lk_valid, fill_en;
    logic [TAG_W-1:0]   lk_tag, fill_tag;
    logic [DATA_W-1:0]  lk_data, fill_data;
    logic               hit_evt, miss_evt;
    logic [2*CNT_W-1:0] counts;

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data)
    );

    dmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
        .hit_evt(hit_evt), .miss_evt(miss_evt)
    );

    dmc_event_count #(.CNT_W(CNT_W), .NUM(2)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .evt({miss_evt, hit_evt}),
        .cnt(counts)
    );

    assign hit_count  = counts[CNT_W-1:0];
    assign miss_count = counts[2*CNT_W-1:CNT_W];
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    logic [ADDR_W-1:0] acc_addr;
    always_ff @(posedge clk) begin
        if (!rst_n) acc_addr <= '0;
        else if (cpu_req && cpu_ready) acc_addr <= cpu_addr;
    end

    a_r2_mem_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == acc_addr));

    a_r6_write_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |=>
        (mem_req && mem_we && mem_addr == $past(cpu_addr) && mem_wdata == $past(cpu_wdata)));

    a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    a_r8_done_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> cpu_done);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hit_count - $past(hit_count)) + (miss_count - $past(miss_count)) <= CNT_W'(1)));

    a_r10_write_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind dmc_cache dmc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sim_dmc_cache.sv
module sim_dmc_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_ready, cpu_done;
    logic [7:0] cpu_rdata;
    logic       mem_req, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic       mem_ready = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic [15:0] hit_count, miss_count;

    always #2 clk = ~clk;

    dmc_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Backing memory model, served at negedges.
    logic [7:0] backing [256];
    logic [7:0] ref_mem [256];
    int mem_lat = 0, wait_cnt = 0, n_rd = 0, n_wr = 0;
    logic [7:0] last_rd_addr = '0;

    always @(negedge clk) begin
        if (mem_ready) mem_ready <= 1'b0;
        else if (mem_req) begin
            if (wait_cnt >= mem_lat) begin
                wait_cnt  <= 0;
                mem_ready <= 1'b1;
                if (mem_we) begin backing[mem_addr] <= mem_wdata; n_wr++; end
                else begin mem_rdata <= backing[mem_addr]; last_rd_addr <= mem_addr; n_rd++; end
            end else wait_cnt <= wait_cnt + 1;
        end
    end

    int  last_cyc;
    bit  ready_low_ok;
    logic [7:0] last_rd;

    task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        last_cyc = 1;
        ready_low_ok = 1;
        while (!cpu_done && last_cyc < 1000) begin
            if (cpu_ready) ready_low_ok = 0;
            @(negedge clk);
            last_cyc++;
        end
        last_rd = cpu_rdata;
        if (we) ref_mem[a] = wd;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] wd;
        logic       hit;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h30, 8'h00, 1'b0},  // R3 cold miss
        '{1'b0, 8'h30, 8'h00, 1'b1},  // R4 hit
        '{1'b0, 8'h31, 8'h00, 1'b0},  // R2 neighbour index
        '{1'b1, 8'h44, 8'hA5, 1'b0},  // R6 write
        '{1'b0, 8'h44, 8'h00, 1'b1},  // R6 read back hits
        '{1'b0, 8'h84, 8'h00, 1'b0},  // R7 same index, other tag
        '{1'b0, 8'h44, 8'h00, 1'b0},  // R7 evicted
        '{1'b1, 8'h07, 8'h3C, 1'b0},
        '{1'b0, 8'h07, 8'h00, 1'b1},
        '{1'b0, 8'hFF, 8'h00, 1'b0},
        '{1'b0, 8'hFF, 8'h00, 1'b1},
        '{1'b0, 8'h30, 8'h00, 1'b1},
        '{1'b1, 8'h10, 8'h99, 1'b0},  // R7 write evicts 0x30
        '{1'b0, 8'h30, 8'h00, 1'b0},
        '{1'b0, 8'h10, 8'h00, 1'b0}   // R7 0x30 refill evicted 0x10
    };

    bit         mv [8];
    logic [4:0] mt [8];
    logic [15:0] lfsr = 16'hACE1;

    initial begin
        for (int i = 0; i < 256; i++) begin
            backing[i] = 8'((i * 29 + 7) ^ 8'h5A);
            ref_mem[i] = backing[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cpu_ready == 1'b1, "R1 ready in reset", cpu_ready, 1);
        check(cpu_done == 1'b0 && mem_req == 1'b0, "R1 idle outputs", {cpu_done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(hit_count == 0 && miss_count == 0, "R1 counters", hit_count + miss_count, 0);

        mem_lat = 0;
        for (int v = 0; v < NV; v++) begin
            int h0, m0, r0, w0;
            h0 = hit_count; m0 = miss_count; r0 = n_rd; w0 = n_wr;
            access(VEC[v].we, VEC[v].addr, VEC[v].wd);
            if (VEC[v].we) begin
                check(backing[VEC[v].addr] == VEC[v].wd, "R6 memory written", backing[VEC[v].addr], VEC[v].wd);
                check(n_wr == w0 + 1, "R6 one memory write", n_wr - w0, 1);
                check(last_cyc == mem_lat + 2, "R8 write latency", last_cyc, mem_lat + 2);
                check(hit_count == h0 && miss_count == m0, "R10 write not counted", hit_count + miss_count, h0 + m0);
            end else begin
                check(last_rd == ref_mem[VEC[v].addr], "R5 read data", last_rd, ref_mem[VEC[v].addr]);
                if (VEC[v].hit) begin
                    check(last_cyc == 1, "R4 hit latency", last_cyc, 1);
                    check(n_rd == r0, "R4 no memory access", n_rd - r0, 0);
                    check(hit_count == h0 + 1, "R10 hit count", hit_count, h0 + 1);
                end else begin
                    check(last_cyc == mem_lat + 2, "R8 miss latency", last_cyc, mem_lat + 2);
                    check(last_rd_addr == VEC[v].addr, "R2 miss address", last_rd_addr, VEC[v].addr);
                    check(miss_count == m0 + 1, "R7 R3 miss count", miss_count, m0 + 1);
                end
            end
        end

        // R8: slow memory keeps ready low
        mem_lat = 5;
        access(1'b0, 8'h5B, 8'h00);
        check(ready_low_ok, "R8 ready low during miss", 0, 1);
        check(last_cyc == 7, "R8 slow miss latency", last_cyc, 7);
        check(last_rd == ref_mem[8'h5B], "R5 slow miss data", last_rd, ref_mem[8'h5B]);
        access(1'b1, 8'h5B, 8'h12);
        check(ready_low_ok && last_cyc == 7, "R8 slow write", last_cyc, 7);
        access(1'b0, 8'h5B, 8'h00);
        check(last_cyc == 1 && last_rd == 8'h12, "R6 write refreshed line", last_rd, 8'h12);

        // R9: request while busy is not taken twice
        begin
            int m0;
            m0 = miss_count;
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'hC2;
            repeat (4) @(negedge clk);
            cpu_req = 1'b0;
            while (!cpu_done) @(negedge clk);
            @(negedge clk);
            check(miss_count == m0 + 1, "R9 single acceptance", miss_count, m0 + 1);
            check(cpu_done == 1'b0, "R9 done is a pulse", cpu_done, 0);
        end

        // R1: reset mid-run invalidates all lines
        do_reset();
        @(negedge clk);
        check(hit_count == 0 && miss_count == 0, "R1 counters after reset", hit_count, 0);
        mem_lat = 1;
        access(1'b0, 8'h5B, 8'h00);
        check(last_cyc == 3 && miss_count == 1, "R1 R3 line invalid after reset", last_cyc, 3);
        check(last_rd == 8'h12, "R6 memory kept write", last_rd, 8'h12);

        // Random phase against flat model with independent tag model
        do_reset();
        for (int i = 0; i < 8; i++) mv[i] = 0;
        begin
            int eh = 0, em = 0, bad = 0;
            for (int n = 0; n < 400; n++) begin
                bit we; logic [7:0] a, wd; bit hit;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                we = (lfsr[2:0] == 3'd0);
                a  = {3'b000, lfsr[9:8], lfsr[5:3]};
                wd = lfsr[15:8];
                mem_lat = lfsr[11:10];
                hit = !we && mv[a[2:0]] && mt[a[2:0]] == a[7:3];
                access(we, a, wd);
                if (!we) begin
                    if (hit) eh++; else em++;
                    if (last_rd != ref_mem[a]) begin
                        bad++;
                        check(0, "R5 random read data", last_rd, ref_mem[a]);
                    end
                    if ((last_cyc == 1) != hit) begin
                        bad++;
                        check(0, "R7 random hit prediction", last_cyc, hit ? 1 : mem_lat + 2);
                    end
                end
                mv[a[2:0]] = 1; mt[a[2:0]] = a[7:3];
            end
            check(bad == 0, "R5 R7 random sequence", bad, 0);
            check(hit_count == 16'(eh), "R10 random hits", hit_count, eh);
            check(miss_count == 16'(em), "R10 random misses", miss_count, em);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule